// File: doc/BRIEF.md
# Match/Capture Timer

This block is a timer/counter with four compare channels and four capture channels. Its counter advances once per system clock, or once per selected transition of a chosen capture channel when an external count signal is used instead of the clock. Each compare channel watches for the counter being equal to its stored value. On that event it can set a sticky interrupt flag, drive an output level, restart the counter or halt it.

Each capture channel takes one raw pin from a small set of candidates. When several candidates are enabled, the lowest-indexed one is used. The chosen pin is synchronized and edge-detected. On the configured transition the channel copies the running count into its own capture register and sets a flag. Software programs the block through a single-cycle write port and reads registers through a combinational read port.

Top module: `mc_timer`

## Requirements
- R1: After reset, every register reads zero, all match pins are low and `irq` is low. The address map is: 0 control, 1 flags, 2 count (read only), 3 match control, 4 capture control, 5 pin enables, 6..9 match values 0..3, 10..13 capture values 0..3 (read only).
- R2: The control register has these fields: bit 0 enable, bit 1 counter hold-reset, bit 2 source (0 = clock, 1 = external), bits 4:3 external channel, bits 6:5 external edge (bit 5 rising, bit 6 falling). In clock mode, while enabled and not held, the counter rises by one every clock cycle.
- R3: While the hold-reset bit is 1, the counter reads 0 and does not advance.
- R4: In external mode the counter rises by one for each selected transition of the chosen capture channel's synchronized input. The input must hold each level for at least two clocks.
- R5: A match event on channel i happens on a count event while the counter equals match value i. Match control is five bits per channel at bit 5i: +0 interrupt enable, +1 restart, +2 halt, +4:+3 output action. With restart set, that count event loads 0. With halt set, the counter keeps its value and the enable bit clears.
- R6: On a match event the channel's output state follows its action code: 00 unchanged, 01 low, 10 high, 11 toggle.
- R7: Pin-enable bit 8+2i+p enables match pin 2i+p. Every enabled pin of channel i shows that channel's state, and disabled pins are 0. The match flag is set even when no pin is enabled.
- R8: Capture control is three bits per channel at bit 3c: +1:+0 edge select (01 rising, 10 falling, 11 both, 00 off) and +2 interrupt enable. A selected transition copies the counter into capture register c within three clocks and sets flag bit 4+c. An unselected transition changes nothing.
- R9: Pin-enable bit 2c+p enables capture pin 2c+p for channel c. When several candidates are enabled, the lowest-index enabled pin drives the channel, and transitions on the other candidates are ignored.
- R10: The flag register holds match flags in bits 3:0 and capture flags in bits 7:4. Flags stay set until software writes 1 to that bit. `irq` is the OR of the flags whose interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| cap_pin | input | 8 | Raw capture candidate pins, two per channel |
| mat_pin | output | 8 | Match output pins, two per channel |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count shows up at the count register on the next read, and it carries forward into every later match and capture. A bad comparison or restart decision changes the wrap period, which is visible within one period of the programmed match value. Wrong output state persists on `mat_pin` until the next match event, so a sequence of random actions exposes it at once. A mistake in synchronization or pin priority shows up as a missing or extra capture flag within about three clocks of a pin transition.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } mat_act_e;

    localparam int A_CTRL   = 0;
    localparam int A_FLAGS  = 1;
    localparam int A_COUNT  = 2;
    localparam int A_MCTL   = 3;
    localparam int A_CCTL   = 4;
    localparam int A_PINEN  = 5;
    localparam int A_MATCH0 = 6;

    localparam int MFW = 5; // ien, restart, halt, action[1:0]
    localparam int CFW = 3; // edge[1:0], ien
endpackage

// File: rtl/mc_pin_pick.sv
module mc_pin_pick #(
    parameter int NCH = 4,
    parameter int NP  = 2
) (
    input  logic [NCH*NP-1:0] pins,
    input  logic [NCH*NP-1:0] en,
    output logic [NCH-1:0]    sel
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic pick;
        always_comb begin
            pick = 1'b0;
            for (int p = NP - 1; p >= 0; p--) begin
                if (en[c*NP+p]) pick = pins[c*NP+p];
            end
        end
        assign sel[c] = pick;
    end
endmodule

// File: rtl/mc_sync_edge.sv
module mc_sync_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, s3_q;
    logic [W-1:0] s1_d, s2_d, s3_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/mc_timer.sv
module mc_timer
    import mc_timer_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NMAT  = 4,
    parameter int NCAP  = 4,
    parameter int NCPIN = 2,
    parameter int NMPIN = 2,
    parameter int AW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [CW-1:0]          rd_data,
    input  logic [NCAP*NCPIN-1:0]  cap_pin,
    output logic [NMAT*NMPIN-1:0]  mat_pin,
    output logic                   irq
);
    localparam int CSW    = (NCAP > 1) ? $clog2(NCAP) : 1;
    localparam int NF     = NMAT + NCAP;
    localparam int CPW    = NCAP * NCPIN;
    localparam int PEW    = CPW + NMAT * NMPIN;
    localparam int A_CAP0 = A_MATCH0 + NMAT;

    typedef struct packed {
        logic [CW-1:0]            cnt;
        logic                     en;
        logic                     crst;
        logic                     mode;
        logic [CSW-1:0]           csel;
        logic [1:0]               cedge;
        logic [NMAT*MFW-1:0]      mctl;
        logic [NCAP*CFW-1:0]      cctl;
        logic [PEW-1:0]           pinen;
        logic [NMAT-1:0][CW-1:0]  mval;
        logic [NCAP-1:0][CW-1:0]  cap;
        logic [NF-1:0]            flags;
        logic [NMAT-1:0]          mstate;
    } st_t;

    st_t st_q, st_d;

    logic [NCAP-1:0] cap_sel, rise, fall, cev, cien;
    logic [NMAT-1:0] hit, mien, mrst, mstop;
    logic [NMAT-1:0][1:0] mact;
    logic cnt_ev, tick;

    mc_pin_pick #(.NCH(NCAP), .NP(NCPIN)) u_pick (
        .pins (cap_pin),
        .en   (st_q.pinen[CPW-1:0]),
        .sel  (cap_sel)
    );

    mc_sync_edge #(.W(NCAP)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_sel),
        .rise  (rise),
        .fall  (fall)
    );

    always_comb begin
        cnt_ev = (rise[st_q.csel] & st_q.cedge[0]) | (fall[st_q.csel] & st_q.cedge[1]);
        tick   = st_q.en & ~st_q.crst & (~st_q.mode | cnt_ev);
    end

    always_comb begin
        for (int i = 0; i < NMAT; i++) begin
            mien[i]  = st_q.mctl[i*MFW];
            mrst[i]  = st_q.mctl[i*MFW+1];
            mstop[i] = st_q.mctl[i*MFW+2];
            mact[i]  = st_q.mctl[i*MFW+3 +: 2];
            hit[i]   = tick && (st_q.cnt == st_q.mval[i]);
        end
        for (int c = 0; c < NCAP; c++) begin
            cien[c] = st_q.cctl[c*CFW+2];
            cev[c]  = (rise[c] & st_q.cctl[c*CFW]) | (fall[c] & st_q.cctl[c*CFW+1]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == AW'(A_CTRL)) begin
                st_d.en    = wr_data[0];
                st_d.crst  = wr_data[1];
                st_d.mode  = wr_data[2];
                st_d.csel  = wr_data[3 +: CSW];
                st_d.cedge = wr_data[3+CSW +: 2];
            end
            if (wr_addr == AW'(A_FLAGS)) st_d.flags = st_q.flags & ~wr_data[NF-1:0];
            if (wr_addr == AW'(A_MCTL))  st_d.mctl  = wr_data[NMAT*MFW-1:0];
            if (wr_addr == AW'(A_CCTL))  st_d.cctl  = wr_data[NCAP*CFW-1:0];
            if (wr_addr == AW'(A_PINEN)) st_d.pinen = wr_data[PEW-1:0];
            for (int i = 0; i < NMAT; i++) begin
                if (wr_addr == AW'(A_MATCH0 + i)) st_d.mval[i] = wr_data;
            end
        end

        if (st_q.crst) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (|(hit & mrst))       st_d.cnt = '0;
            else if (|(hit & mstop)) st_d.cnt = st_q.cnt;
            else                     st_d.cnt = st_q.cnt + CW'(1);
        end
        if (|(hit & mstop)) st_d.en = 1'b0;

        for (int i = 0; i < NMAT; i++) begin
            if (hit[i]) begin
                case (mact[i])
                    ACT_LOW:    st_d.mstate[i] = 1'b0;
                    ACT_HIGH:   st_d.mstate[i] = 1'b1;
                    ACT_TOGGLE: st_d.mstate[i] = ~st_q.mstate[i];
                    default:    st_d.mstate[i] = st_q.mstate[i];
                endcase
            end
        end

        for (int c = 0; c < NCAP; c++) begin
            if (cev[c]) st_d.cap[c] = st_q.cnt;
        end
        st_d.flags = st_d.flags | {cev, hit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CTRL))
            rd_data = CW'({st_q.cedge, st_q.csel, st_q.mode, st_q.crst, st_q.en});
        if (rd_addr == AW'(A_FLAGS)) rd_data = CW'(st_q.flags);
        if (rd_addr == AW'(A_COUNT)) rd_data = st_q.cnt;
        if (rd_addr == AW'(A_MCTL))  rd_data = CW'(st_q.mctl);
        if (rd_addr == AW'(A_CCTL))  rd_data = CW'(st_q.cctl);
        if (rd_addr == AW'(A_PINEN)) rd_data = CW'(st_q.pinen);
        for (int i = 0; i < NMAT; i++) begin
            if (rd_addr == AW'(A_MATCH0 + i)) rd_data = st_q.mval[i];
        end
        for (int c = 0; c < NCAP; c++) begin
            if (rd_addr == AW'(A_CAP0 + c)) rd_data = st_q.cap[c];
        end
    end

    for (genvar m = 0; m < NMAT; m++) begin : g_mat
        for (genvar p = 0; p < NMPIN; p++) begin : g_pin
            assign mat_pin[m*NMPIN+p] = st_q.mstate[m] & st_q.pinen[CPW + m*NMPIN + p];
        end
    end

    assign irq = |(st_q.flags & {cien, mien});
endmodule

module mc_timer_chk
    import mc_timer_pkg::*;
#(
    parameter int CW   = 32,
    parameter int NMAT = 4,
    parameter int NCAP = 4,
    parameter int AW   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [CW-1:0]          cnt,
    input logic                   en,
    input logic                   crst,
    input logic                   mode,
    input logic [NMAT-1:0]        hit,
    input logic [NMAT-1:0]        mstop,
    input logic [NMAT+NCAP-1:0]   flags,
    input logic [NCAP-1:0][CW-1:0] cap
);
    // R2
    clock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !crst && !mode && hit == '0) |=> (cnt == $past(cnt) + CW'(1)));

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst |=> (cnt == '0));

    // R5
    halt_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & mstop)) |=> !en);

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(A_FLAGS)) |=> ((flags & $past(flags)) == $past(flags)));

    for (genvar c = 0; c < NCAP; c++) begin : g_cap
        // R8
        cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap[c] != $past(cap[c])) |-> flags[NMAT+c]);
    end
endmodule

bind mc_timer mc_timer_chk #(.CW(CW), .NMAT(NMAT), .NCAP(NCAP), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cnt     (st_q.cnt),
    .en      (st_q.en),
    .crst    (st_q.crst),
    .mode    (st_q.mode),
    .hit     (hit),
    .mstop   (mstop),
    .flags   (st_q.flags),
    .cap     (st_q.cap)
);

// File: tb/mc_timer_tb.sv
`timescale 1ns/1ps
module mc_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  cap_pin = '0;
    logic [7:0]  mat_pin;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    mc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin), .mat_pin(mat_pin), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = a[3:0];
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic next_mat(input logic s, input logic [1:0] a);
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~s;
            default: return s;
        endcase
    endfunction

    function automatic int wrap_count(input int n, input int m);
        return n % (m + 1);
    endfunction

    task automatic pulse(input int bitn, input int times);
        for (int i = 0; i < times; i++) begin
            cap_pin[bitn] = 1'b1; idle(2);
            cap_pin[bitn] = 1'b0; idle(2);
        end
        idle(4);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        ms;
        int          k, c, c2, e;
        void'($urandom(32'd2718));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(0, v);  chk("R1 ctrl", v, 0);
        rd(1, v);  chk("R1 flags", v, 0);
        rd(2, v);  chk("R1 count", v, 0);
        rd(10, v); chk("R1 cap0", v, 0);
        chk("R1 mat_pin", {24'd0, mat_pin}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 clock-mode counting
        wr(0, 32'h1);
        k = 5 + int'($urandom % 36);
        idle(k);
        rd(2, v); chk("R2 count", v, k);

        // R3 hold-reset
        wr(0, 32'h3);
        idle(5);
        rd(2, v); chk("R3 held", v, 0);
        wr(0, 32'h0);

        // R5 restart on match, random periods
        for (int r = 0; r < 4; r++) begin
            int m, n;
            m = 3 + int'($urandom % 18);
            n = 30 + int'($urandom % 51);
            wr(0, 32'h2);
            wr(6, m);
            wr(3, 32'h2);
            wr(0, 32'h1);
            idle(n);
            rd(2, v); chk("R5 wrap", v, wrap_count(n, m));
            rd(1, v); chk("R5 flag0", v & 1, 1);
            wr(0, 32'h0);
            wr(1, 32'hFF);
            rd(1, v); chk("R10 cleared", v, 0);
        end

        // R5 halt + R6 random actions, pins of channel 1 enabled
        k = 2 + int'($urandom % 14);
        ms = 1'b0;
        wr(6, k);
        wr(7, k);
        wr(5, 32'hC00);
        for (int r = 0; r < 8; r++) begin
            logic [1:0] act;
            act = 2'($urandom);
            wr(3, 32'h4 | (32'(act) << 8));
            wr(0, 32'h2);
            wr(0, 32'h1);
            idle(k + 4);
            ms = next_mat(ms, act);
            rd(2, v); chk("R5 halted count", v, k);
            rd(0, v); chk("R5 enable cleared", v & 1, 0);
            chk("R6 match pins", {30'd0, mat_pin[3:2]}, {30'd0, ms, ms});
        end

        // R7 only one pin enabled
        wr(5, 32'h400);
        chk("R7 enabled pin", {31'd0, mat_pin[2]}, {31'd0, ms});
        chk("R7 disabled pin", {31'd0, mat_pin[3]}, 0);

        // R7 flag without any pin
        wr(5, 32'h0);
        wr(1, 32'hFF);
        wr(3, 32'h4 | (32'h3 << 8));
        wr(0, 32'h2);
        wr(0, 32'h1);
        idle(k + 4);
        rd(1, v); chk("R7 flag no pin", (v >> 1) & 1, 1);
        chk("R7 pins low", {24'd0, mat_pin}, 0);

        // R10 interrupt enables and write-one-to-clear
        wr(3, 32'h1 << 5);
        chk("R10 irq on", {31'd0, irq}, 1);
        wr(1, 32'h1);
        chk("R10 irq kept", {31'd0, irq}, 1);
        wr(1, 32'h2);
        chk("R10 irq off", {31'd0, irq}, 0);
        rd(1, v); chk("R10 bit1 clear", (v >> 1) & 1, 0);
        wr(1, 32'hFF);
        wr(3, 32'h0);

        // R8/R9 capture with counter halted at k
        c = int'($urandom % 4);
        wr(4, 32'h5 << (3 * c));
        wr(5, 32'h3 << (2 * c));
        cap_pin[2*c+1] = 1'b1; idle(5);
        rd(10 + c, v); chk("R9 higher pin ignored", v, 0);
        rd(1, v);      chk("R9 no flag", v, 0);
        cap_pin[2*c] = 1'b1; idle(5);
        rd(10 + c, v); chk("R8 captured", v, k);
        rd(1, v);      chk("R8 flag", v, 32'h1 << (4 + c));
        chk("R8 irq", {31'd0, irq}, 1);
        wr(1, 32'hFF);
        cap_pin[2*c] = 1'b0; idle(5);
        rd(1, v);      chk("R8 fall ignored", v, 0);
        wr(4, 32'h2 << (3 * c));
        cap_pin[2*c] = 1'b1; idle(5);
        rd(1, v);      chk("R8 rise ignored", v, 0);
        cap_pin[2*c] = 1'b0; idle(5);
        rd(1, v);      chk("R8 fall captured", v, 32'h1 << (4 + c));
        cap_pin = '0; idle(4);
        wr(1, 32'hFF);
        wr(4, 32'h0);

        // R4 external count mode
        c2 = int'($urandom % 4);
        e  = 3 + int'($urandom % 18);
        wr(5, 32'h1 << (2 * c2));
        wr(0, 32'h2);
        wr(0, 32'h5 | (32'(c2) << 3) | (32'h1 << 5));
        pulse(2 * c2, e);
        rd(2, v); chk("R4 rising count", v, e);
        wr(0, 32'h2);
        wr(0, 32'h5 | (32'(c2) << 3) | (32'h3 << 5));
        pulse(2 * c2, e);
        rd(2, v); chk("R4 both-edge count", v, 2 * e);

        finish_run();
    end
endmodule